// File: doc/BRIEF.md
# Circular Free Physical Register List

This block keeps the pool of unused physical register indices for one register class in a multi-issue rename stage. The pool is a circular queue. Up to `ALLOC_W` slots can request a register in a cycle, and each requesting slot reads an index from the head in slot order. Up to `COMMIT_W` commit ports return the previous mapping of a retired destination at the tail. The allocation port reports whether a full group of `ALLOC_W` registers is available. Rename must stall while that signal is low.

Recovery after a misprediction does not restore a snapshot. Each walk cycle, the head pointer moves back by the number of walked entries that had taken a register from this class. A flush jumps the head straight to the committed position. At that position every register outside the architectural mapping is free again. The consumption enable is meant to be driven from the other class's grant ANDed with downstream ready, so that both lists advance together.

Top module: `free_reg_list`

## Requirements
- R1: After reset the queue holds the indices `NUM_ARCH` to `NUM_PREGS-1` in ascending order, and the head points at `NUM_ARCH`. With every slot requesting, slot k shows `NUM_ARCH+k`, and `can_alloc` is high.
- R2: Slot k (bit k of `alloc_req`, field k of `alloc_preg` at bits `[k*PRW +: PRW]`) shows the entry at head plus the number of requesting slots with a lower index.
- R3: The head advances by the number of set `alloc_req` bits only when `do_alloc` and `can_alloc` are high and `walk`, `redirect` and `flush` are all low. Otherwise allocation consumes nothing.
- R4: `can_alloc` is high exactly when at least `ALLOC_W` free entries remain.
- R5: On a cycle with `walk` low, each commit port i with both `commit_valid[i]` and `commit_wen[i]` set pushes `commit_old_preg[i*PRW +: PRW]` at the tail in port order. While `walk` is high, nothing is pushed.
- R6: On a walk cycle without flush, the head moves back by the count of ports with both `commit_valid` and `commit_wen` set.
- R7: The committed position advances by the pushed count on every non-walk cycle. A flush sets the head to the committed position after that cycle's commits, returning all speculative allocations.
- R8: A flush has priority over walk and allocation in the same cycle.
- R9: Pointers wrap around the queue so that long mixed traffic keeps allocation order consistent with the push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Return head to committed position |
| redirect | input | 1 | Redirect cycle; blocks allocation |
| walk | input | 1 | Misprediction walk in progress |
| alloc_req | input | ALLOC_W | Per-slot request for a register |
| do_alloc | input | 1 | Consumption enable from the other class and downstream |
| alloc_preg | output | ALLOC_W*PRW | Index offered to each slot |
| can_alloc | output | 1 | At least ALLOC_W free entries |
| commit_valid | input | COMMIT_W | Commit/walk port valid |
| commit_wen | input | COMMIT_W | Port writes a destination of this class |
| commit_old_preg | input | COMMIT_W*PRW | Previous mapping to release |

## Verification
The hardest situation to reach is a near-empty queue, where `can_alloc` falls. Reaching it requires a run of granted groups with no commits in between. The bench makes it directly by allocating full groups until the grant drops. It then shows that requests made while the grant is low consume nothing, and refills the queue with commits that carry chosen old indices. After that, random traffic runs that keeps walks and commits within the count of outstanding allocations. Random flushes and redirects are mixed in, so that the pointers wrap many times.

// File: rtl/free_reg_list.sv
module free_reg_list #(
  parameter int NUM_PREGS = 64,
  parameter int NUM_ARCH  = 32,
  parameter int ALLOC_W   = 4,
  parameter int COMMIT_W  = 4,
  localparam int PRW      = $clog2(NUM_PREGS),
  localparam int DEPTH    = NUM_PREGS - NUM_ARCH,
  localparam int QW       = $clog2(DEPTH),
  localparam int PTRW     = QW + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    redirect,
  input  logic                    walk,
  input  logic [ALLOC_W-1:0]      alloc_req,
  input  logic                    do_alloc,
  output logic [ALLOC_W*PRW-1:0]  alloc_preg,
  output logic                    can_alloc,
  input  logic [COMMIT_W-1:0]     commit_valid,
  input  logic [COMMIT_W-1:0]     commit_wen,
  input  logic [COMMIT_W*PRW-1:0] commit_old_preg
);
  // DEPTH must be a power of two: pointers carry one wrap bit above the index.
  logic [PRW-1:0]      q [DEPTH];
  logic [PTRW-1:0]     head, tail, arch_head;
  logic [PTRW-1:0]     req_pre [ALLOC_W+1];
  logic [PTRW-1:0]     rel_pre [COMMIT_W+1];
  logic [PTRW-1:0]     wr_ptr  [COMMIT_W];
  logic [COMMIT_W-1:0] rel_en;
  logic [PTRW-1:0]     free_cnt;
  logic                fire;

  assign rel_en    = commit_valid & commit_wen;
  assign free_cnt  = tail - head;
  assign can_alloc = free_cnt >= PTRW'(ALLOC_W);
  assign fire      = do_alloc & can_alloc & ~walk & ~redirect & ~flush;

  always_comb begin
    req_pre[0] = '0;
    for (int k = 0; k < ALLOC_W; k++)
      req_pre[k+1] = req_pre[k] + PTRW'(alloc_req[k]);
    rel_pre[0] = '0;
    for (int i = 0; i < COMMIT_W; i++) begin
      rel_pre[i+1] = rel_pre[i] + PTRW'(rel_en[i]);
      wr_ptr[i]    = tail + rel_pre[i];
    end
  end

  for (genvar k = 0; k < ALLOC_W; k++) begin : g_slot
    logic [PTRW-1:0] rd_ptr;
    assign rd_ptr = head + req_pre[k];
    assign alloc_preg[k*PRW +: PRW] = q[rd_ptr[QW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= PRW'(NUM_ARCH + i);
    end else if (!walk) begin
      for (int i = 0; i < COMMIT_W; i++)
        if (rel_en[i]) q[wr_ptr[i][QW-1:0]] <= commit_old_preg[i*PRW +: PRW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head      <= '0;
      tail      <= PTRW'(DEPTH);
      arch_head <= '0;
    end else begin
      if (!walk) begin
        tail      <= tail + rel_pre[COMMIT_W];
        arch_head <= arch_head + rel_pre[COMMIT_W];
      end
      if (flush)     head <= walk ? arch_head : arch_head + rel_pre[COMMIT_W];
      else if (walk) head <= head - rel_pre[COMMIT_W];
      else if (fire) head <= head + req_pre[ALLOC_W];
    end
  end
endmodule

// File: rtl/free_reg_list_chk.sv
module free_reg_list_chk #(
  parameter int PTRW     = 6,
  parameter int DEPTH    = 32,
  parameter int COMMIT_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                flush,
  input logic                walk,
  input logic                do_alloc,
  input logic [COMMIT_W-1:0] commit_valid,
  input logic [COMMIT_W-1:0] commit_wen,
  input logic [PTRW-1:0]     head,
  input logic [PTRW-1:0]     tail,
  input logic [PTRW-1:0]     arch_head
);
  localparam logic [PTRW:0] DEPTH_V = DEPTH[PTRW:0];
  logic [PTRW-1:0] walk_cnt;
  logic [PTRW-1:0] occ;
  assign walk_cnt = PTRW'($countones(commit_valid & commit_wen));
  assign occ      = tail - head;

  assert_walk_stepback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (walk && !flush) |=> head == $past(head) - $past(walk_cnt));

  assert_walk_no_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    walk |=> $stable(tail));

  assert_hold_no_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !walk && !do_alloc) |=> $stable(head));

  assert_flush_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> head == arch_head);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, occ} <= DEPTH_V);
endmodule

bind free_reg_list free_reg_list_chk #(.PTRW(PTRW), .DEPTH(DEPTH), .COMMIT_W(COMMIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .walk(walk), .do_alloc(do_alloc),
  .commit_valid(commit_valid), .commit_wen(commit_wen),
  .head(head), .tail(tail), .arch_head(arch_head));

// File: tb/tb_free_reg_list.sv
`timescale 1ns/1ps
module tb_free_reg_list;
  localparam int NP = 64, NA = 32, W = 4, C = 4;
  localparam int PRW = $clog2(NP);
  localparam int DEPTH = NP - NA;

  logic clk = 0, rst_n = 0;
  logic flush = 0, redirect = 0, walk = 0, do_alloc = 0;
  logic [W-1:0] alloc_req = '0;
  logic [W*PRW-1:0] alloc_preg;
  logic can_alloc;
  logic [C-1:0] commit_valid = '0, commit_wen = '0;
  logic [C*PRW-1:0] commit_old_preg = '0;

  free_reg_list #(.NUM_PREGS(NP), .NUM_ARCH(NA), .ALLOC_W(W), .COMMIT_W(C)) dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int mq [DEPTH];
  int mh, mt, ma;

  function automatic int exp_slot(input int k);
    int pre = 0;
    for (int j = 0; j < k; j++) pre += alloc_req[j];
    return mq[(mh + pre) % DEPTH];
  endfunction

  function automatic bit exp_can();
    return (mt - mh) >= W;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [W-1:0] rq, input logic da, input logic wk, input logic rd,
                      input logic fl, input logic [C-1:0] cv, input logic [C-1:0] cw,
                      input logic [C*PRW-1:0] old, input string tag);
    int ne, nr;
    bit fire;
    alloc_req = rq; do_alloc = da; walk = wk; redirect = rd; flush = fl;
    commit_valid = cv; commit_wen = cw; commit_old_preg = old;
    #1;
    chk({tag, " can_alloc"}, int'(can_alloc), int'(exp_can()));
    for (int k = 0; k < W; k++)
      if (rq[k]) chk({tag, " slot"}, int'(alloc_preg[k*PRW +: PRW]), exp_slot(k));
    fire = da && exp_can() && !wk && !rd && !fl;
    nr = $countones(rq);
    ne = 0;
    @(posedge clk);
    if (!wk) begin
      for (int i = 0; i < C; i++)
        if (cv[i] && cw[i]) begin
          mq[(mt + ne) % DEPTH] = int'(old[i*PRW +: PRW]);
          ne++;
        end
      mt += ne; ma += ne;
    end else begin
      for (int i = 0; i < C; i++) if (cv[i] && cw[i]) ne++;
    end
    if (fl)        mh = ma;
    else if (wk)   mh -= ne;
    else if (fire) mh += nr;
    @(negedge clk);
  endtask

  function automatic logic [C-1:0] trim(input logic [C-1:0] cv, input logic [C-1:0] cw);
    logic [C-1:0] r = cw;
    int lim = mh - ma, n = 0;
    for (int i = 0; i < C; i++)
      if (cv[i] && r[i]) begin
        if (n >= lim) r[i] = 1'b0; else n++;
      end
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [C-1:0] cv, cw;
    logic [C*PRW-1:0] old;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) mq[i] = NA + i;
    mh = 0; ma = 0; mt = DEPTH;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset contents
    step(4'b1111, 0, 0, 0, 0, '0, '0, '0, "R1");
    chk("R1 slot0", int'(alloc_preg[0 +: PRW]), NA);
    // R2 slot order with gaps
    step(4'b1010, 1, 0, 0, 0, '0, '0, '0, "R2");
    step(4'b0110, 1, 0, 0, 0, '0, '0, '0, "R2");
    step(4'b1111, 0, 0, 0, 0, '0, '0, '0, "R3");
    // R3 walk and redirect block consumption
    step(4'b1111, 1, 1, 0, 0, '0, '0, '0, "R3");
    step(4'b1111, 1, 0, 1, 0, '0, '0, '0, "R3");
    step(4'b1111, 0, 0, 0, 0, '0, '0, '0, "R3");
    // R6 walk step-back, invalid ports ignored
    step(4'b0000, 0, 1, 0, 0, 4'b1011, 4'b0110, {C*PRW{1'b1}}, "R6");
    step(4'b1111, 0, 0, 0, 0, '0, '0, '0, "R6");
    // R4 drain to empty
    for (int g = 0; g < 9; g++) step(4'b1111, 1, 0, 0, 0, '0, '0, '0, "R4");
    step(4'b1111, 1, 0, 0, 0, '0, '0, '0, "R4");
    // R5 refill with chosen old indices, then walk pushes nothing
    old = {6'd17, 6'd13, 6'd9, 6'd5};
    step(4'b0000, 0, 0, 0, 0, 4'b1111, 4'b1111, old, "R5");
    step(4'b0000, 0, 1, 0, 0, 4'b0011, 4'b0011, {6'd60, 6'd61, 6'd62, 6'd63}, "R5");
    step(4'b1111, 1, 0, 0, 0, '0, '0, '0, "R5");
    step(4'b1111, 0, 0, 0, 0, '0, '0, '0, "R5");
    // R7 flush returns speculative registers
    step(4'b0001, 0, 0, 0, 1, 4'b0001, 4'b0001, {4{6'd40}}, "R7");
    step(4'b1111, 0, 0, 0, 0, '0, '0, '0, "R7");
    // R8 flush beats walk and allocation
    step(4'b1111, 1, 0, 0, 0, '0, '0, '0, "R8");
    step(4'b1111, 1, 1, 0, 1, 4'b0001, 4'b0001, '0, "R8");
    step(4'b1111, 1, 0, 0, 1, '0, '0, '0, "R8");
    step(4'b1111, 0, 0, 0, 0, '0, '0, '0, "R8");
    // R9 random traffic with wraparound
    for (int n = 0; n < 3000; n++) begin
      logic wk, rd, fl, da;
      wk = ($urandom % 10) == 0;
      rd = ($urandom % 20) == 0;
      fl = ($urandom % 50) == 0;
      da = ($urandom % 5) != 0;
      cv = C'($urandom);
      cw = trim(cv, C'($urandom));
      for (int i = 0; i < C; i++) old[i*PRW +: PRW] = PRW'($urandom % NP);
      step(W'($urandom), da, wk, rd, fl, cv, cw, old, "R9");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule